// File: doc/BRIEF.md
# SPI Shift-Register Transfer Engine

This block is a register-programmed SPI master that moves a burst of 1 to 32 bits per command. Software first places the word to transmit in an output-data register. It then writes a command register that holds a start flag, a chip-select choice, an end-of-transaction flag and a bit count. The engine produces the serial clock, shifts the transmit bits out on MOSI and samples MISO into a receive register. When the burst ends it clears the start flag, so software learns of completion by polling that flag.

A command that leaves the end-of-transaction flag clear keeps its chip select low after the burst. A longer transaction can therefore be built from several commands. The serial clock is the system clock divided by 2*(div+1), with a 6-bit divider. The idle level of each chip-select line comes from a pin-control register, whose reset value sets all three lines high. Access to every register except the gate register is blocked until the gate bit is set.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset the gate register reads 0, the serial clock and MOSI are low, all three chip-select outputs are high, and once the gate is opened the divider reads 0 and the pin-control register reads 0x0007_0000.
- R2: While bit 0 of the gate register (offset 0x00) is 0, writes to offsets 0x04, 0x08, 0x10 and 0x14 are ignored and reads of them return 0.
- R3: A write to the command register (offset 0x14) with bit 31 set and a count (bits 6:0) that is not 0 starts a burst. Bit 31 reads 1 from the next cycle for exactly count*2*(div+1) cycles and then reads 0. A count above 32 is run as 32.
- R4: Command bits 30:28 pick chip select 0, 1 or 2, and the lowest set bit wins. The chosen output goes low from the cycle after the start, and the others keep their idle level.
- R5: With command bit 26 set, the chosen chip select returns to its idle level when the burst ends. With bit 26 clear, it stays low until a later command that has bit 26 set ends.
- R6: The serial clock is low whenever no burst runs. During a burst it first rises div+1 cycles after the start and then toggles every div+1 cycles, where div is bits 5:0 of offset 0x04.
- R7: MOSI carries bits N-1 down to 0 of the output-data register (offset 0x10), most significant first. It changes only at the start and on falling serial-clock edges, and it is low when idle.
- R8: MISO is sampled on each rising serial-clock edge. The receive register (offset 0x18) then holds the N bits right-aligned, with the last bit in bit 0 and zeros above.
- R9: The receive register changes only in the cycle a burst ends.
- R10: While a burst runs, writes to the divider, output-data and command registers are ignored, including a write that lands in the cycle the burst ends.
- R11: Bits 18:16 of the pin-control register (offset 0x08) give the idle level of chip-select outputs 2:0, and the register may be rewritten at any time.
- R12: A start with count 0 is ignored. Bit 31 stays 0 and no pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
Two events can fall in the same cycle: a register write and the end of a burst. A write to the output-data register presented on the exact edge where the last falling serial-clock edge clears the busy flag must still be refused. The bench counts edges from the start command so that the write lands in that cycle. It then reads the register back and confirms the old word is still present, while the per-cycle model confirms that the busy flag, MOSI and the chip selects behave as specified.

// File: rtl/spi_eng_pkg.sv
`timescale 1ns/1ps
package spi_eng_pkg;
  localparam int WORD_W   = 32;
  localparam int CNT_W    = $clog2(WORD_W + 1);
  localparam int NUM_CS   = 3;
  localparam int START_B  = 31;
  localparam int SEL_B    = 28;
  localparam int TERM_B   = 26;
  localparam int CNTF_W   = 7;
  localparam int IOC_CS_B = 16;
  localparam logic [WORD_W-1:0] IOC_RST = 32'h0007_0000;

  localparam int OFS_GATE = 'h00;
  localparam int OFS_DIVR = 'h04;
  localparam int OFS_PINS = 'h08;
  localparam int OFS_TXW  = 'h10;
  localparam int OFS_CMD  = 'h14;
  localparam int OFS_RXW  = 'h18;

  // bit count actually run for a count field (saturates at the word width)
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNTF_W-1:0] f);
    if (f > CNTF_W'(WORD_W)) return CNT_W'(WORD_W);
    return f[CNT_W-1:0];
  endfunction

  // move the right-aligned N-bit field to the top so the first bit is the MSB
  function automatic logic [WORD_W-1:0] align_tx(input logic [WORD_W-1:0] w,
                                                 input logic [CNT_W-1:0] n);
    return w << (CNT_W'(WORD_W) - n);
  endfunction

  // lowest set request wins
  function automatic logic [NUM_CS-1:0] pick_cs(input logic [NUM_CS-1:0] req);
    logic [NUM_CS-1:0] g;
    g = '0;
    for (int i = NUM_CS - 1; i >= 0; i--) begin
      if (req[i]) g = NUM_CS'(1) << i;
    end
    return g;
  endfunction
endpackage

// File: rtl/spi_eng_regs.sv
`timescale 1ns/1ps
module spi_eng_regs
  import spi_eng_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic                busy,
  input  logic [WORD_W-1:0]   rx_word,
  output logic [DIV_W-1:0]    div,
  output logic [NUM_CS-1:0]   cs_idle,
  output logic [WORD_W-1:0]   tx_word,
  output logic                start,
  output logic [CNT_W-1:0]    start_cnt,
  output logic [NUM_CS-1:0]   start_sel,
  output logic                start_term,
  output logic                div_wr_req
);
  logic                gate_q;
  logic [DIV_W-1:0]    div_q;
  logic [WORD_W-1:0]   pins_q;
  logic [WORD_W-1:0]   txw_q;
  logic [NUM_CS-1:0]   cmd_sel_q;
  logic                cmd_term_q;
  logic [CNTF_W-1:0]   cmd_cnt_q;

  logic hit_gate, hit_div, hit_pins, hit_txw, hit_cmd, hit_rxw;
  logic wr_open, wr_idle;

  assign hit_gate = bus_addr == ADDR_W'(OFS_GATE);
  assign hit_div  = bus_addr == ADDR_W'(OFS_DIVR);
  assign hit_pins = bus_addr == ADDR_W'(OFS_PINS);
  assign hit_txw  = bus_addr == ADDR_W'(OFS_TXW);
  assign hit_cmd  = bus_addr == ADDR_W'(OFS_CMD);
  assign hit_rxw  = bus_addr == ADDR_W'(OFS_RXW);

  assign wr_open    = bus_we && gate_q;
  assign wr_idle    = wr_open && !busy;
  assign div_wr_req = wr_open && hit_div;

  assign start_cnt  = eff_count(bus_wdata[CNTF_W-1:0]);
  assign start_sel  = pick_cs(bus_wdata[SEL_B +: NUM_CS]);
  assign start_term = bus_wdata[TERM_B];
  assign start      = wr_idle && hit_cmd && bus_wdata[START_B] && (start_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q     <= 1'b0;
      div_q      <= '0;
      pins_q     <= IOC_RST;
      txw_q      <= '0;
      cmd_sel_q  <= '0;
      cmd_term_q <= 1'b0;
      cmd_cnt_q  <= '0;
    end else begin
      if (bus_we && hit_gate) gate_q <= bus_wdata[0];
      if (wr_open && hit_pins) pins_q <= bus_wdata;
      if (wr_idle && hit_div)  div_q  <= bus_wdata[DIV_W-1:0];
      if (wr_idle && hit_txw)  txw_q  <= bus_wdata;
      if (wr_idle && hit_cmd) begin
        cmd_sel_q  <= bus_wdata[SEL_B +: NUM_CS];
        cmd_term_q <= bus_wdata[TERM_B];
        cmd_cnt_q  <= bus_wdata[CNTF_W-1:0];
      end
    end
  end

  assign div     = div_q;
  assign cs_idle = pins_q[IOC_CS_B +: NUM_CS];
  assign tx_word = txw_q;

  always_comb begin
    bus_rdata = '0;
    if (hit_gate) begin
      bus_rdata[0] = gate_q;
    end else if (gate_q) begin
      if (hit_div)  bus_rdata[DIV_W-1:0] = div_q;
      if (hit_pins) bus_rdata = pins_q;
      if (hit_txw)  bus_rdata = txw_q;
      if (hit_rxw)  bus_rdata = rx_word;
      if (hit_cmd) begin
        bus_rdata[START_B]            = busy;
        bus_rdata[SEL_B +: NUM_CS]    = cmd_sel_q;
        bus_rdata[TERM_B]             = cmd_term_q;
        bus_rdata[CNTF_W-1:0]         = cmd_cnt_q;
      end
    end
  end
endmodule

// File: rtl/spi_eng_shifter.sv
`timescale 1ns/1ps
module spi_eng_shifter
  import spi_eng_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    div,
  input  logic                start,
  input  logic [CNT_W-1:0]    start_cnt,
  input  logic [NUM_CS-1:0]   start_sel,
  input  logic                start_term,
  input  logic [WORD_W-1:0]   tx_word,
  input  logic                miso,
  output logic                busy,
  output logic                sclk,
  output logic                mosi,
  output logic [NUM_CS-1:0]   cs_act,
  output logic [WORD_W-1:0]   rx_word,
  output logic                edge_rise,
  output logic                edge_fall,
  output logic                done
);
  logic                busy_q, sclk_q, term_q;
  logic [DIV_W-1:0]    half_q;
  logic [CNT_W-1:0]    left_q;
  logic [WORD_W-1:0]   tx_q, rx_q, rxw_q;
  logic [NUM_CS-1:0]   cs_q;
  logic                half_end;

  assign half_end  = busy_q && (half_q == div);
  assign edge_rise = half_end && !sclk_q;
  assign edge_fall = half_end && sclk_q;
  assign done      = edge_fall && (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      term_q <= 1'b0;
      half_q <= '0;
      left_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      rxw_q  <= '0;
      cs_q   <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sclk_q <= 1'b0;
      half_q <= '0;
      left_q <= start_cnt;
      tx_q   <= align_tx(tx_word, start_cnt);
      rx_q   <= '0;
      cs_q   <= start_sel;
      term_q <= start_term;
    end else if (busy_q) begin
      if (half_end) begin
        half_q <= '0;
        if (edge_rise) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[WORD_W-2:0], miso};
        end else begin
          sclk_q <= 1'b0;
          tx_q   <= tx_q << 1;
          left_q <= left_q - CNT_W'(1);
          if (done) begin
            busy_q <= 1'b0;
            rxw_q  <= rx_q;
            if (term_q) cs_q <= '0;
          end
        end
      end else begin
        half_q <= half_q + DIV_W'(1);
      end
    end
  end

  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = busy_q && tx_q[WORD_W-1];
  assign cs_act  = cs_q;
  assign rx_word = rxw_q;
endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DIV_W  = 6,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [2:0]        spi_cs_n
);
  logic [DIV_W-1:0]  div;
  logic [NUM_CS-1:0] cs_idle, start_sel, cs_act;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic [CNT_W-1:0]  start_cnt;
  logic start, start_term, div_wr_req, busy, edge_rise, edge_fall, done;

  spi_eng_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .rx_word(rx_word),
    .div(div), .cs_idle(cs_idle), .tx_word(tx_word),
    .start(start), .start_cnt(start_cnt), .start_sel(start_sel),
    .start_term(start_term), .div_wr_req(div_wr_req)
  );

  spi_eng_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .div(div),
    .start(start), .start_cnt(start_cnt), .start_sel(start_sel), .start_term(start_term),
    .tx_word(tx_word), .miso(spi_miso),
    .busy(busy), .sclk(spi_sclk), .mosi(spi_mosi), .cs_act(cs_act), .rx_word(rx_word),
    .edge_rise(edge_rise), .edge_fall(edge_fall), .done(done)
  );

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = cs_act[i] ? 1'b0 : cs_idle[i];
  end
endmodule

// File: rtl/spi_shift_engine_chk.sv
`timescale 1ns/1ps
module spi_shift_engine_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             start,
  input logic             done,
  input logic             edge_fall,
  input logic             sclk,
  input logic             mosi,
  input logic [2:0]       cs_act,
  input logic [31:0]      rx_word,
  input logic [DIV_W-1:0] div,
  input logic             div_wr_req
);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_cs_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_act));
  p_term_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (busy == 1'b0));
  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  p_mosi_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mosi);
  p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !edge_fall) |=> $stable(mosi));
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rx_word));
  p_div_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && div_wr_req) |=> $stable(div));
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .done(done),
  .edge_fall(edge_fall), .sclk(spi_sclk), .mosi(spi_mosi), .cs_act(cs_act),
  .rx_word(rx_word), .div(div), .div_wr_req(div_wr_req)
);

// File: tb/tb_spi_shift_engine.sv
`timescale 1ns/1ps
module tb_spi_shift_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic sclk, mosi, miso;
  logic [2:0] cs_n;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  spi_shift_engine dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(sclk),
    .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
  );

  always #2.5 clk = ~clk;

  // slave side: MISO pattern, MOSI capture on rising SCLK
  logic [31:0] spat = '0;
  logic [31:0] cap = '0;
  int sk = 0;
  assign miso = (sk < 32) ? spat[31 - sk] : 1'b0;
  always @(posedge sclk) begin
    cap = {cap[30:0], mosi};
    sk++;
  end

  // behavioural reference model, advanced on every rising clock
  bit m_en, m_busy, m_term;
  int m_div, m_k, m_n;
  logic [31:0] m_ioc, m_dout, m_word;
  logic [2:0] m_cs;

  always @(posedge clk) begin
    bit ob;
    int n;
    if (!rst_n) begin
      m_en = 0; m_busy = 0; m_term = 0; m_div = 0; m_k = 0; m_n = 0;
      m_ioc = 32'h0007_0000; m_dout = 0; m_word = 0; m_cs = 0;
    end else begin
      ob = m_busy;
      if (m_busy) begin
        m_k++;
        if (m_k == m_n * 2 * (m_div + 1)) begin
          m_busy = 0;
          if (m_term) m_cs = 0;
        end
      end
      if (bus_we) begin
        if (bus_addr == 5'h00) m_en = bus_wdata[0];
        else if (m_en) begin
          if (bus_addr == 5'h08) m_ioc = bus_wdata;
          if (!ob && bus_addr == 5'h04) m_div = bus_wdata[5:0];
          if (!ob && bus_addr == 5'h10) m_dout = bus_wdata;
          if (!ob && bus_addr == 5'h14) begin
            n = bus_wdata[6:0];
            if (n > 32) n = 32;
            if (bus_wdata[31] && n > 0) begin
              m_busy = 1; m_k = 0; m_n = n; m_word = m_dout; m_term = bus_wdata[26];
              if (bus_wdata[28]) m_cs = 3'b001;
              else if (bus_wdata[29]) m_cs = 3'b010;
              else if (bus_wdata[30]) m_cs = 3'b100;
              else m_cs = 3'b000;
            end
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // compare pins against the model on every falling clock (R4 R5 R6 R7 R11 R12)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int h;
      logic e_sclk, e_mosi;
      logic [2:0] e_cs;
      h = m_div + 1;
      e_sclk = m_busy && (((m_k / h) % 2) == 1);
      e_mosi = m_busy && m_word[m_n - 1 - m_k / (2 * h)];
      for (int i = 0; i < 3; i++) e_cs[i] = m_cs[i] ? 1'b0 : m_ioc[16 + i];
      chk("R6 sclk", {31'b0, sclk}, {31'b0, e_sclk});
      chk("R7 mosi", {31'b0, mosi}, {31'b0, e_mosi});
      chk("R4/R5/R11 cs_n", {29'b0, cs_n}, {29'b0, e_cs});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // start a burst and return the number of cycles the busy flag read 1
  task automatic run(input logic [31:0] cmd, input logic [31:0] pat, output int cyc);
    logic [31:0] r;
    spat = pat; sk = 0; cap = 0;
    wr(5'h14, cmd);
    cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      rd(5'h14, r);
      if (!r[31]) break;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int cyc;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(5'h00, r); chk("R1 gate", r, 0);
    chk("R1 pins", {29'b0, cs_n, sclk, mosi} , {29'b0, 3'b111, 1'b0, 1'b0});
    rst_n = 1;
    @(negedge clk);
    // R2: gate closed blocks writes and reads
    wr(5'h04, 32'h2A);
    wr(5'h08, 32'h0);
    rd(5'h08, r); chk("R2 read closed", r, 0);
    wr(5'h00, 1);
    rd(5'h04, r); chk("R2/R1 div", r, 0);
    rd(5'h08, r); chk("R11/R1 pins reset", r, 32'h0007_0000);

    // R7 R8 R5: 8 bits, div 0, cs0, terminate
    wr(5'h10, 32'h0000_00A5);
    run(32'h8400_0000 | (1 << 28) | 8, 32'h3C00_0000, cyc);
    chk("R3 busy len 8b d0", cyc, 16);
    rd(5'h18, r); chk("R8 rx 8b", r, 32'h3C);
    chk("R7 tx 8b", cap, 32'hA5);
    chk("R5 cs released", {29'b0, cs_n}, 32'h7);

    // R3 R8: 32 bits, div 2, cs2
    wr(5'h04, 2);
    wr(5'h10, 32'h1234_5678);
    run(32'h8400_0000 | (1 << 30) | 32, 32'hCAFE_F00D, cyc);
    chk("R3 busy len 32b d2", cyc, 192);
    rd(5'h18, r); chk("R8 rx 32b", r, 32'hCAFE_F00D);
    chk("R7 tx 32b", cap, 32'h1234_5678);

    // R5: hold across two commands on cs1 (bits 29 and 30 set: R4 lowest wins)
    wr(5'h04, 0);
    wr(5'h10, 32'h9);
    run(32'h8000_0000 | (3 << 29) | 4, 32'h5000_0000, cyc);
    chk("R5 cs held", {29'b0, cs_n}, 32'b101);
    rd(5'h18, r); chk("R8 rx 4b", r, 32'h5);
    wr(5'h10, 32'hABC);
    run(32'h8400_0000 | (1 << 29) | 12, 32'h7E50_0000, cyc);
    chk("R5 cs end", {29'b0, cs_n}, 32'h7);
    rd(5'h18, r); chk("R8 rx 12b", r, 32'h7E5);
    chk("R7 tx 12b", cap, 32'hABC);

    // R10 R9: writes during a burst
    wr(5'h04, 3);
    wr(5'h10, 32'h0000_BEEF);
    spat = 32'hF0F0_0000; sk = 0; cap = 0;
    wr(5'h14, 32'h8400_0000 | (1 << 28) | 16);
    wr(5'h10, 32'h0000_FFFF);
    wr(5'h04, 0);
    rd(5'h18, r); chk("R9 rx mid-burst", r, 32'h7E5);
    wr(5'h14, 32'h8400_0000 | (1 << 30) | 3);
    repeat (140) @(negedge clk);
    rd(5'h04, r); chk("R10 div kept", r, 3);
    rd(5'h10, r); chk("R10 txw kept", r, 32'h0000_BEEF);
    rd(5'h14, r); chk("R10 cmd kept", r, 32'h0400_0000 | (1 << 28) | 16);
    rd(5'h18, r); chk("R8 rx 16b", r, 32'hF0F0);
    chk("R7 tx 16b", cap, 32'hBEEF);

    // R3: count above 32 runs as 32
    wr(5'h04, 0);
    run(32'h8400_0000 | (1 << 28) | 40, 32'h0, cyc);
    chk("R3 clamp", cyc, 64);

    // R12: count 0 ignored
    wr(5'h14, 32'h8400_0000 | (1 << 28));
    rd(5'h14, r); chk("R12 no start", {31'b0, r[31]}, 0);
    repeat (4) @(negedge clk);
    chk("R12 pins", {29'b0, cs_n, sclk, mosi}, {29'b0, 3'b111, 2'b00});

    // R11: idle level from pin-control
    wr(5'h08, 32'h0005_0000);
    chk("R11 idle cs", {29'b0, cs_n}, 32'b101);
    wr(5'h08, 32'h0007_0000);

    // R10: output-data write in the exact completion cycle (8 bits, div 1 => 32 cycles)
    wr(5'h04, 1);
    wr(5'h10, 32'h66);
    spat = 0; sk = 0;
    wr(5'h14, 32'h8400_0000 | (1 << 28) | 8);
    repeat (31) @(negedge clk);
    bus_we = 1; bus_addr = 5'h10; bus_wdata = 32'h99;
    @(negedge clk);
    bus_we = 0;
    rd(5'h14, r); chk("R3 done at edge", {31'b0, r[31]}, 0);
    rd(5'h10, r); chk("R10 completion-cycle write", r, 32'h66);

    // R2: closing the gate hides registers
    wr(5'h00, 0);
    rd(5'h10, r); chk("R2 hidden", r, 0);
    rd(5'h00, r); chk("R2 gate read", r, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule